// File: doc/BRIEF.md
# Ping-Pong Triggered History Readout

This block keeps a rolling record of per-channel time-to-digital words and, when a trigger arrives, turns a programmable window of that record into a zero-suppressed stream of FIFO pushes. Every cycle, each channel's fine time and hit-valid flag are written into that channel's RAM. Each RAM is split into two pages. One page takes writes, and the other page holds a frozen copy of the most recent history.

A trigger swaps the two pages. The page that was just filled becomes readable and recording carries on in the other page with no lost cycle. A single master counter then walks the selected window. For each recorded cycle it takes all channels at once and interleaves them into one stream, one channel per clock. Only slots whose valid flag is set reach the FIFO. Each pushed word is tagged with its coarse time and channel number. Every event starts with a header word that carries an event number and the trigger's coarse time. The FIFO's almost-full status is copied into every word so that downstream logic can tell when data may have been lost.

Top module: `pingpong_readout`

## Requirements
- R1: Reset (synchronous, active high) clears all pushes. The coarse time counter holds 0 in the first cycle after reset is released and then adds one every cycle. The first accepted event is numbered 0.
- R2: Every cycle, each channel's {valid, fine} pair is stored under the current coarse time. A trigger accepted in coarse cycle n, with look-back L1 (0..127) and length L2 (1..128, L2 ≤ L1+1), reads coarse times n−L1 through n−L1+L2−1 for every channel.
- R3: An accepted trigger swaps the write and read pages. Recording continues in the following cycle with no gap. A later trigger at least 128 cycles after the previous one therefore reads data recorded since that previous trigger.
- R4: Window addresses wrap modulo 128 inside the read page. A window that crosses address 0 returns the correct coarse times.
- R5: The header is pushed in cycle n+1. The slot for window row i (0-based) and channel ch is pushed in cycle n+4+4i+ch. Pushes come in ascending coarse time and, within one coarse time, in ascending channel order.
- R6: A slot is pushed only if its stored valid flag is 1. No other words are pushed, so a window with no valid hits yields only the header.
- R7: Data word (default widths, 50 bits): bit 49 = 0, bit 48 = almost-full, bits 47:40 = 0, bits 39:8 = coarse time, bits 7:6 = channel, bits 5:0 = fine time.
- R8: Header word: bit 49 = 1, bit 48 = almost-full, bits 47:32 = event number, bits 31:0 = coarse time of the trigger cycle. Each accepted event's number is one more than the previous event's number.
- R9: While a readout is in flight, a trigger is ignored: no header is pushed and the event number does not advance. This covers cycles n+1 through n+4·L2+2. A trigger in cycle n+4·L2+3 is accepted.
- R10: Bit 48 of each pushed word equals the almost-full input as sampled in the cycle before the push appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_fine | input | NCH*FT_W | Per-channel fine time, channel c in bits [c*FT_W +: FT_W] |
| ch_valid | input | NCH | Per-channel hit-valid flag |
| trig | input | 1 | Trigger request, sampled every cycle |
| win_back | input | PAGE_AW | Look-back L1, in cycles before the trigger |
| win_len | input | PAGE_AW+1 | Window length L2, in coarse cycles (1..128) |
| fifo_afull | input | 1 | Almost-full status of the downstream FIFO |
| fifo_push | output | 1 | Push strobe |
| fifo_word | output | OUT_W | Header or data word |

## Verification
On every cycle the checker confirms four properties: the output stays quiet right after reset, a header appears only after a sampled trigger and is followed by one idle cycle, consecutive data pushes advance the {coarse time, channel} slot by exactly one, and event numbers step by one. The bench scenarios are needed to show that stored contents are correct, window placement and wrap are correct, suppression of invalid slots works, the exact cycle of each push is right, the almost-full tag is carried, and a trigger on the last busy cycle is ignored while one on the next cycle is taken.

// File: rtl/pingpong_readout_pkg.sv
package pingpong_readout_pkg;
  typedef enum logic {
    WORD_DATA   = 1'b0,
    WORD_HEADER = 1'b1
  } word_kind_e;
endpackage

// File: rtl/pingpong_readout_ram.sv
// One channel's history store: write every cycle, registered read.
module pingpong_readout_ram #(
  parameter int DW = 7,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    mem[wr_addr] <= wr_data;
    rd_data      <= mem[rd_addr];
  end
endmodule

// File: rtl/pingpong_readout_seq.sv
// Coarse time, page select, event number and the master readout counter.
module pingpong_readout_seq #(
  parameter int NCH     = 4,
  parameter int PAGE_AW = 7,
  parameter int TC_W    = 32,
  parameter int EV_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          trig,
  input  logic [PAGE_AW-1:0]            win_back,
  input  logic [PAGE_AW:0]              win_len,
  input  logic                          pipe_busy,
  output logic                          accept,
  output logic [TC_W-1:0]               tc,
  output logic [EV_W-1:0]               ev_num,
  output logic [PAGE_AW:0]              wr_addr,
  output logic [PAGE_AW:0]              rd_addr,
  output logic                          rd_act,
  output logic                          rd_ld,
  output logic [TC_W+$clog2(NCH)-1:0]   slot
);
  localparam int CH_W = $clog2(NCH);
  localparam int EN_W = PAGE_AW + 1 + CH_W;

  logic            wr_page;
  logic [EN_W-1:0] en_cnt;

  assign rd_act = (en_cnt != '0);
  assign accept = trig && !rd_act && !pipe_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc      <= '0;
      wr_page <= 1'b0;
      ev_num  <= '0;
      en_cnt  <= '0;
      slot    <= '0;
    end else begin
      tc <= tc + 1'b1;
      if (accept) begin
        wr_page <= ~wr_page;
        ev_num  <= ev_num + 1'b1;
        en_cnt  <= {win_len, {CH_W{1'b0}}};
        slot    <= {tc - TC_W'(win_back), {CH_W{1'b0}}};
      end else if (rd_act) begin
        en_cnt <= en_cnt - 1'b1;
        slot   <= slot + 1'b1;
      end
    end
  end

  assign wr_addr = {wr_page, tc[PAGE_AW-1:0]};
  assign rd_addr = {~wr_page, slot[CH_W +: PAGE_AW]};
  assign rd_ld   = rd_act && (slot[CH_W-1:0] == '0);
endmodule

// File: rtl/pingpong_readout_cat.sv
// Load/shift concentration, zero suppression and word formatting.
module pingpong_readout_cat
  import pingpong_readout_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int FT_W  = 6,
  parameter int TC_W  = 32,
  parameter int EV_W  = 16,
  parameter int OUT_W = 50
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NCH*(FT_W+1)-1:0]     rd_cells,
  input  logic                        rd_act,
  input  logic                        rd_ld,
  input  logic [TC_W+$clog2(NCH)-1:0] slot,
  input  logic                        accept,
  input  logic [EV_W-1:0]             ev_num,
  input  logic [TC_W-1:0]             tc,
  input  logic                        fifo_afull,
  output logic                        pipe_busy,
  output logic                        fifo_push,
  output logic [OUT_W-1:0]            fifo_word
);
  localparam int CH_W   = $clog2(NCH);
  localparam int CELL_W = FT_W + 1;
  localparam int SLOT_W = TC_W + CH_W;
  localparam int PAY_W  = OUT_W - 2;

  logic              ld_d1, act_d1, act_d2;
  logic [SLOT_W-1:0] slot_d1, slot_d2;
  logic [CELL_W-1:0] sh [NCH];
  logic [PAY_W-1:0]  hdr_pay, dat_pay;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_d1  <= 1'b0;
      act_d1 <= 1'b0;
      act_d2 <= 1'b0;
    end else begin
      ld_d1  <= rd_ld;
      act_d1 <= rd_act;
      act_d2 <= act_d1;
    end
    slot_d1 <= slot;
    slot_d2 <= slot_d1;
  end

  // Parallel load of all channels, then one word per cycle toward sh[0].
  always_ff @(posedge clk) begin
    if (ld_d1) begin
      for (int i = 0; i < NCH; i++) sh[i] <= rd_cells[i*CELL_W +: CELL_W];
    end else begin
      for (int i = 0; i < NCH - 1; i++) sh[i] <= sh[i+1];
      sh[NCH-1] <= '0;
    end
  end

  assign pipe_busy = act_d1 || act_d2;
  assign hdr_pay   = PAY_W'({ev_num, tc});
  assign dat_pay   = PAY_W'({slot_d2, sh[0][FT_W-1:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_push <= 1'b0;
      fifo_word <= '0;
    end else begin
      fifo_push <= 1'b0;
      if (accept) begin
        fifo_push <= 1'b1;
        fifo_word <= {WORD_HEADER, fifo_afull, hdr_pay};
      end else if (act_d2 && sh[0][FT_W]) begin
        fifo_push <= 1'b1;
        fifo_word <= {WORD_DATA, fifo_afull, dat_pay};
      end
    end
  end
endmodule

// File: rtl/pingpong_readout.sv
module pingpong_readout #(
  parameter int NCH     = 4,
  parameter int FT_W    = 6,
  parameter int PAGE_AW = 7,
  parameter int TC_W    = 32,
  parameter int EV_W    = 16,
  parameter int CH_W    = $clog2(NCH),
  parameter int DAT_PAY = TC_W + CH_W + FT_W,
  parameter int HDR_PAY = EV_W + TC_W,
  parameter int OUT_W   = ((DAT_PAY > HDR_PAY) ? DAT_PAY : HDR_PAY) + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH*FT_W-1:0]   ch_fine,
  input  logic [NCH-1:0]        ch_valid,
  input  logic                  trig,
  input  logic [PAGE_AW-1:0]    win_back,
  input  logic [PAGE_AW:0]      win_len,
  input  logic                  fifo_afull,
  output logic                  fifo_push,
  output logic [OUT_W-1:0]      fifo_word
);
  localparam int CELL_W = FT_W + 1;

  logic                     accept, rd_act, rd_ld, pipe_busy;
  logic [TC_W-1:0]          tc;
  logic [EV_W-1:0]          ev_num;
  logic [PAGE_AW:0]         wr_addr, rd_addr;
  logic [TC_W+CH_W-1:0]     slot;
  logic [NCH*CELL_W-1:0]    rd_cells;

  pingpong_readout_seq #(
    .NCH(NCH), .PAGE_AW(PAGE_AW), .TC_W(TC_W), .EV_W(EV_W)
  ) u_seq (
    .clk(clk), .rst(rst), .trig(trig), .win_back(win_back), .win_len(win_len),
    .pipe_busy(pipe_busy), .accept(accept), .tc(tc), .ev_num(ev_num),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_act(rd_act), .rd_ld(rd_ld),
    .slot(slot)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pingpong_readout_ram #(.DW(CELL_W), .AW(PAGE_AW + 1)) u_ram (
      .clk(clk),
      .wr_addr(wr_addr),
      .wr_data({ch_valid[c], ch_fine[c*FT_W +: FT_W]}),
      .rd_addr(rd_addr),
      .rd_data(rd_cells[c*CELL_W +: CELL_W])
    );
  end

  pingpong_readout_cat #(
    .NCH(NCH), .FT_W(FT_W), .TC_W(TC_W), .EV_W(EV_W), .OUT_W(OUT_W)
  ) u_cat (
    .clk(clk), .rst(rst), .rd_cells(rd_cells), .rd_act(rd_act), .rd_ld(rd_ld),
    .slot(slot), .accept(accept), .ev_num(ev_num), .tc(tc),
    .fifo_afull(fifo_afull), .pipe_busy(pipe_busy),
    .fifo_push(fifo_push), .fifo_word(fifo_word)
  );
endmodule

// File: rtl/pingpong_readout_chk.sv
module pingpong_readout_chk #(
  parameter int OUT_W = 50,
  parameter int TC_W  = 32,
  parameter int CH_W  = 2,
  parameter int FT_W  = 6,
  parameter int EV_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic             fifo_push,
  input logic [OUT_W-1:0] fifo_word
);
  logic                   hdr, dat, seen;
  logic [TC_W+CH_W-1:0]   slot;
  logic [EV_W-1:0]        ev, last_ev;

  assign hdr  = fifo_push && fifo_word[OUT_W-1];
  assign dat  = fifo_push && !fifo_word[OUT_W-1];
  assign slot = fifo_word[FT_W +: TC_W+CH_W];
  assign ev   = fifo_word[TC_W +: EV_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      last_ev <= '0;
    end else if (hdr) begin
      seen    <= 1'b1;
      last_ev <= ev;
    end
  end

  // R1
  no_push_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fifo_push);

  // R8
  hdr_after_trig_chk: assert property (@(posedge clk) disable iff (rst)
    hdr |-> $past(trig));

  // R5
  hdr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    hdr |=> !fifo_push);

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dat && $past(dat)) |-> (slot == $past(slot) + 1'b1));

  // R8
  ev_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hdr && seen) |-> (ev == last_ev + 1'b1));
endmodule

bind pingpong_readout pingpong_readout_chk #(
  .OUT_W(OUT_W), .TC_W(TC_W), .CH_W(CH_W), .FT_W(FT_W), .EV_W(EV_W)
) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .fifo_push(fifo_push), .fifo_word(fifo_word)
);

// File: tb/sim_pingpong_readout.sv
module sim_pingpong_readout;
  localparam int NCH   = 4;
  localparam int FT_W  = 6;
  localparam int OUT_W = 50;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst = 1'b1, trig = 1'b0, fifo_afull = 1'b0;
  logic [6:0]          win_back = '0;
  logic [7:0]          win_len = 8'd1;
  logic [NCH*FT_W-1:0] ch_fine = '0;
  logic [NCH-1:0]      ch_valid = '0;
  logic                fifo_push;
  logic [OUT_W-1:0]    fifo_word;

  pingpong_readout u0 (
    .clk(clk), .rst(rst), .ch_fine(ch_fine), .ch_valid(ch_valid), .trig(trig),
    .win_back(win_back), .win_len(win_len), .fifo_afull(fifo_afull),
    .fifo_push(fifo_push), .fifo_word(fifo_word)
  );

  int checks = 0, fails = 0, cyc = 0, busy_until = 0, last_trig = -1000, ev = 0;
  bit done = 1'b0;
  logic [OUT_W-1:0] exp_w[$];
  int               exp_c[$];
  string            exp_t[$];

  function automatic bit vbit(int ch, int c);
    if (c >= 2000 && c < 2600) return 1'b0;
    if (c >= 3000 && c < 3600) return 1'b1;
    return ((c * 5 + ch * 3) % 7) < 3;
  endfunction

  function automatic logic [5:0] fval(int ch, int c);
    return 6'((c * 11 + ch * 17 + c / 64) % 64);
  endfunction

  task automatic drive();
    for (int ch = 0; ch < NCH; ch++) begin
      ch_valid[ch] = vbit(ch, cyc);
      ch_fine[ch*FT_W +: FT_W] = fval(ch, cyc);
    end
  endtask

  task automatic step(bit t, string tag);
    @(negedge clk);
    cyc++;
    if (fifo_push === 1'b1) begin
      checks++;
      if (exp_w.size() == 0) begin
        fails++;
        $display("FAIL R6 R9 %s: unexpected push %h at cycle %0d, expected no push", tag, fifo_word, cyc);
      end else begin
        logic [OUT_W-1:0] w;
        int c;
        string et;
        w = exp_w.pop_front(); c = exp_c.pop_front(); et = exp_t.pop_front();
        if (fifo_word !== w || cyc != c) begin
          fails++;
          $display("FAIL %s: got %h at cycle %0d, expected %h at cycle %0d", et, fifo_word, cyc, w, c);
        end
      end
    end
    drive();
    trig = t;
    if (t && cyc >= busy_until) begin
      exp_w.push_back({1'b1, fifo_afull, 16'(ev), 32'(cyc)});
      exp_c.push_back(cyc + 1);
      exp_t.push_back({"R8 R1 header ", tag});
      for (int i = 0; i < int'(win_len); i++) begin
        for (int ch = 0; ch < NCH; ch++) begin
          int c;
          c = cyc - int'(win_back) + i;
          if (vbit(ch, c)) begin
            exp_w.push_back({1'b0, fifo_afull, 8'h00, 32'(c), 2'(ch), fval(ch, c)});
            exp_c.push_back(cyc + 4 + 4 * i + ch);
            exp_t.push_back({"R2 R5 R7 R10 slot ", tag});
          end
        end
      end
      ev++;
      busy_until = cyc + 4 * int'(win_len) + 3;
      last_trig = cyc;
    end
  endtask

  task automatic drain(string tag);
    while (cyc < busy_until + 2) step(1'b0, tag);
    trig = 1'b0;
    checks++;
    if (exp_w.size() != 0) begin
      fails++;
      $display("FAIL R6 %s: %0d expected words never pushed, expected 0", tag, exp_w.size());
    end
    exp_w.delete(); exp_c.delete(); exp_t.delete();
  endtask

  task automatic wait_ready(int min_cyc, int phase, string tag);
    while (cyc < busy_until + 2 || cyc < last_trig + 130 || cyc < min_cyc ||
           (phase >= 0 && ((cyc + 1) % 128) != phase)) step(1'b0, tag);
  endtask

  task automatic run_event(int l1, int l2, bit af, int min_cyc, int phase, string tag);
    win_back = 7'(l1); win_len = 8'(l2); fifo_afull = af;
    wait_ready(min_cyc, phase, tag);
    step(1'b1, tag);
    drain(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0; cyc = 0; drive();
    checks++;
    if (fifo_push !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: push=%b, expected 0", fifo_push);
    end
    run_event(0, 1, 1'b0, 0, -1, "R1 R2 first event, minimum window");
    run_event(10, 4, 1'b0, 0, -1, "R2 R3 short window");
    run_event(127, 128, 1'b0, 0, 5, "R4 full window wrapping address 0");
    run_event(127, 1, 1'b0, 0, -1, "R2 oldest single row");
    run_event(60, 20, 1'b1, 0, -1, "R10 almost-full tagged");
    run_event(50, 30, 1'b0, 2200, -1, "R6 no valid hits");
    run_event(64, 65, 1'b0, 3200, 100, "R4 R5 all valid");
    run_event(100, 33, 1'b0, 0, 30, "R3 R4 mid window wrap");
    // R9: triggers during readout are dropped; the first free cycle is accepted
    win_back = 7'd39; win_len = 8'd40; fifo_afull = 1'b0;
    wait_ready(0, -1, "R9 busy");
    step(1'b1, "R9 busy");
    repeat (20) step(1'b0, "R9 busy");
    step(1'b1, "R9 mid-readout trigger");
    while (cyc < busy_until - 2) step(1'b0, "R9 busy");
    step(1'b1, "R9 last busy cycle");
    step(1'b1, "R9 first free cycle");
    drain("R9 busy boundary");
    run_event(5, 6, 1'b1, 0, -1, "R8 R10 event after boundary");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule